// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog built around a 12-bit down-counter that steps once per slow-clock enable pulse. Software keeps the system alive by writing a keyed restart command to the control address. The restart is honoured only once the count has fallen to or below a programmable window delta. A restart that comes too early counts as a fault, and so does letting the counter run out. Each fault can drive a reset request, an interrupt, or both. The fault flags stay set until a status read clears them.

Configuration sits in a 32-bit mode word. It holds the reload value, the window delta, a disable bit, the two fault-routing enables and two halt enables, which pause counting while the idle or debug input is high. A keyed lock command freezes the mode word until the next hardware reset. For three slow-clock pulses after an accepted restart, mode writes are dropped, so a reload cannot race a reconfiguration.

Top module: `wwdt_top`

## Requirements
- R1: After reset the count is 0xFFF, both flags and both outputs are low, and the mode word is 0x3FFF2FFF. That value gives a reload value and delta of 0xFFF, counting enabled, reset routing on, interrupt routing off and both halts on. The block is unlocked.
- R2: While running, the count drops by one on each cycle with `tick_i` high. With no tick and no write, the count holds.
- R3: A tick that arrives at count 0 while running reloads the count from the reload field and sets the underflow flag.
- R4: A write to address 0 is a control command. It acts only when bits 31:24 hold 0xA5. Bit 0 requests a restart and bit 1 requests a lock. With any other key the command has no effect.
- R5: A restart when the count is at or below the delta field reloads the count from the reload field. Address 1 holds the mode word: bits 11:0 are the reload value, bit 12 the interrupt enable, bit 13 the reset enable, bit 15 the disable bit, bits 27:16 the delta, bit 28 the debug halt and bit 29 the idle halt.
- R6: A restart when the count is above the delta sets the error flag. The count is not reloaded and does not step in that cycle.
- R7: `wdt_rst_o` is high while bit 13 is set and either flag is set. `irq_o` is high while bit 12 is set and either flag is set. With both enables clear, both outputs stay low.
- R8: With bit 15 set, the count holds, restart commands are ignored and no flag is raised.
- R9: With bit 29 set, counting pauses while `idle_i` is high. With bit 28 set, counting pauses while `debug_i` is high. With the halt bits clear, these inputs do not pause counting.
- R10: After a lock command, mode writes are ignored until the next hardware reset. After that reset, mode writes work again.
- R11: A mode write is ignored until three tick pulses have arrived since the last accepted restart.
- R12: The flags are sticky. A cycle with `stat_rd_i` high clears them, but a fault raised in that same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| tick_i | input | 1 | Slow-clock enable pulse, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 selects control, 1 selects mode |
| wr_data_i | input | 32 | Write data |
| stat_rd_i | input | 1 | Status read strobe; clears the flags |
| idle_i | input | 1 | System idle state |
| debug_i | input | 1 | Processor debug state |
| count_o | output | 12 | Current counter value |
| unf_flag_o | output | 1 | Sticky underflow flag |
| err_flag_o | output | 1 | Sticky window-error flag |
| wdt_rst_o | output | 1 | Watchdog reset request |
| irq_o | output | 1 | Fault interrupt |

## Verification
The counter and the flags drive ports directly. A wrong count therefore shows on `count_o` in the cycle after the tick or restart that caused it, and a missing or stray fault shows on the flags and the routed outputs in that same cycle. Damage to the mode word, the lock or the guard window shows only later, when a restart reloads the wrong value or a window comparison gives the wrong result. For that reason the bench follows every ignored-write scenario with a restart that exposes the stored value. A cycle-accurate model, run over keyed and unkeyed random traffic, compares every port on every cycle.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int CNT_W       = 12;
  localparam int DATA_W      = 32;
  localparam int KEY_W       = 8;
  localparam logic [KEY_W-1:0] CMD_KEY = 8'hA5;
  localparam int GUARD_TICKS = 3;
  localparam int GUARD_W     = $clog2(GUARD_TICKS + 1);
  localparam logic [DATA_W-1:0] MODE_RST = 32'h3FFF_2FFF;

  // bit positions the software view depends on
  localparam int B_IRQ_EN  = 12;
  localparam int B_RST_EN  = 13;
  localparam int B_DIS     = 15;
  localparam int B_WDD     = 16;
  localparam int B_DBG_HLT = 28;
  localparam int B_IDL_HLT = 29;
  localparam int B_RESTART = 0;
  localparam int B_LOCK    = 1;

  typedef struct packed {
    logic             idle_hlt;
    logic             dbg_hlt;
    logic [CNT_W-1:0] wdd;
    logic             dis;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] wdv;
  } mode_t;

  function automatic mode_t unpack_mode(input logic [DATA_W-1:0] d);
    mode_t m;
    m.idle_hlt = d[B_IDL_HLT];
    m.dbg_hlt  = d[B_DBG_HLT];
    m.wdd      = d[B_WDD +: CNT_W];
    m.dis      = d[B_DIS];
    m.rst_en   = d[B_RST_EN];
    m.irq_en   = d[B_IRQ_EN];
    m.wdv      = d[CNT_W-1:0];
    return m;
  endfunction
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              restart_ok_i,
  output mode_t             mode_o,
  output logic              restart_cmd_o,
  output logic              lock_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);

  mode_t              mode_q;
  logic               lock_q;
  logic [GUARD_W-1:0] guard_q;
  logic               key_ok, mode_we;

  assign key_ok  = wr_en_i && (wr_addr_i == A_CTRL) &&
                   (wr_data_i[DATA_W-1 -: KEY_W] == CMD_KEY);
  assign mode_we = wr_en_i && (wr_addr_i == A_MODE) && !lock_q && (guard_q == '0);
  assign restart_cmd_o = key_ok && wr_data_i[B_RESTART];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= unpack_mode(MODE_RST);
      lock_q  <= 1'b0;
      guard_q <= '0;
    end else begin
      if (mode_we) mode_q <= unpack_mode(wr_data_i);
      if (key_ok && wr_data_i[B_LOCK]) lock_q <= 1'b1;
      // settle window after an accepted restart, counted in slow ticks
      if (restart_ok_i)                 guard_q <= GUARD_W'(GUARD_TICKS);
      else if (tick_i && guard_q != '0) guard_q <= guard_q - 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             idle_i,
  input  logic             debug_i,
  input  mode_t            mode_i,
  input  logic             restart_cmd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             restart_ok_o,
  output logic             unf_evt_o,
  output logic             err_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic run, restart_en, in_win, step;

  assign run = !mode_i.dis && !(mode_i.idle_hlt && idle_i) &&
               !(mode_i.dbg_hlt && debug_i);
  assign restart_en   = restart_cmd_i && !mode_i.dis;
  assign in_win       = (cnt_q <= mode_i.wdd);
  assign restart_ok_o = restart_en && in_win;
  assign err_evt_o    = restart_en && !in_win;
  // a restart attempt owns the cycle; the tick is dropped
  assign step         = !restart_en && tick_i && run;
  assign unf_evt_o    = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= unpack_mode(MODE_RST).wdv;
    else if (restart_ok_o)        cnt_q <= mode_i.wdv;
    else if (unf_evt_o)           cnt_q <= mode_i.wdv;
    else if (step)                cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wwdt_flags.sv
module wwdt_flags
  import wwdt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  unf_evt_i,
  input  logic  err_evt_i,
  input  logic  clr_i,
  input  mode_t mode_i,
  output logic  unf_o,
  output logic  err_o,
  output logic  rst_req_o,
  output logic  irq_o
);
  logic unf_q, err_q, any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      unf_q <= unf_evt_i || (unf_q && !clr_i);
      err_q <= err_evt_i || (err_q && !clr_i);
    end
  end

  assign any       = unf_q || err_q;
  assign rst_req_o = mode_i.rst_en && any;
  assign irq_o     = mode_i.irq_en && any;
  assign unf_o     = unf_q;
  assign err_o     = err_q;
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  input  logic              idle_i,
  input  logic              debug_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              unf_flag_o,
  output logic              err_flag_o,
  output logic              wdt_rst_o,
  output logic              irq_o
);
  mode_t mode_q;
  logic  restart_cmd, restart_ok, unf_evt, err_evt, lock_q;

  wwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .restart_ok_i (restart_ok),
    .mode_o       (mode_q),
    .restart_cmd_o(restart_cmd),
    .lock_o       (lock_q)
  );

  wwdt_core u_core (
    .clk_i, .rst_ni, .tick_i, .idle_i, .debug_i,
    .mode_i       (mode_q),
    .restart_cmd_i(restart_cmd),
    .cnt_o        (count_o),
    .restart_ok_o (restart_ok),
    .unf_evt_o    (unf_evt),
    .err_evt_o    (err_evt)
  );

  wwdt_flags u_flags (
    .clk_i, .rst_ni,
    .unf_evt_i(unf_evt),
    .err_evt_i(err_evt),
    .clr_i    (stat_rd_i),
    .mode_i   (mode_q),
    .unf_o    (unf_flag_o),
    .err_o    (err_flag_o),
    .rst_req_o(wdt_rst_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
  import wwdt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              stat_rd_i,
  input logic              idle_i,
  input logic              debug_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              unf_flag_o,
  input logic              err_flag_o,
  input logic              wdt_rst_o,
  input logic              irq_o,
  input mode_t             mode_q,
  input logic              lock_q
);
  logic run_w;
  assign run_w = !mode_q.dis && !(mode_q.idle_hlt && idle_i) && !(mode_q.dbg_hlt && debug_i);

  assert_hold_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_en_i |=> $stable(count_o));

  assert_underflow_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && tick_i && run_w && count_o == '0 |=> count_o == $past(mode_q.wdv) && unf_flag_o);

  assert_quiet_when_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unf_flag_o && !err_flag_o |-> !wdt_rst_o && !irq_o);

  assert_disabled_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.dis |=> $stable(count_o) && !$rose(unf_flag_o) && !$rose(err_flag_o));

  assert_lock_sticks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_locked_mode_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(mode_q));

  assert_unf_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_flag_o && !stat_rd_i |=> unf_flag_o);

  assert_err_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o && !stat_rd_i |=> err_flag_o);
endmodule

bind wwdt_top wwdt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .stat_rd_i, .idle_i, .debug_i,
  .count_o, .unf_flag_o, .err_flag_o, .wdt_rst_o, .irq_o,
  .mode_q(mode_q), .lock_q(lock_q)
);

// File: tb/wwdt_top_test.sv
`timescale 1ns/1ps
module wwdt_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, stat_rd_i = 1'b0, idle_i = 1'b0, debug_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [11:0] count_o;
  logic        unf_flag_o, err_flag_o, wdt_rst_o, irq_o;

  wwdt_top uut (.*);

  always #5 clk_i = ~clk_i;

  int errors = 0, checks = 0, cycles = 0;

  // reference model state
  logic [11:0] m_cnt, m_wdv, m_wdd;
  logic        m_ih, m_dh, m_dis, m_ren, m_ien, m_lock, m_unf, m_err;
  int          m_guard;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mode(input logic ih, dh, input logic [11:0] wdd,
                                          input logic dis, ren, ien, input logic [11:0] wdv);
    return {2'b00, ih, dh, wdd, dis, 1'b0, ren, ien, wdv};
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic [7:0] key, input logic lk, rs);
    return {key, 22'd0, lk, rs};
  endfunction

  task automatic model_reset();
    m_cnt = 12'hFFF; m_wdv = 12'hFFF; m_wdd = 12'hFFF;
    m_ih = 1; m_dh = 1; m_dis = 0; m_ren = 1; m_ien = 0;
    m_lock = 0; m_unf = 0; m_err = 0; m_guard = 0;
  endtask

  task automatic model_step(input logic tk, we, input logic [1:0] ad, input logic [31:0] d,
                            input logic rd, idl, dbg);
    logic key_ok, rs_en, run, fu, fe, acc, mw;
    key_ok = we && ad == 2'd0 && d[31:24] == 8'hA5;
    rs_en  = key_ok && d[0] && !m_dis;
    run    = !m_dis && !(m_ih && idl) && !(m_dh && dbg);
    mw     = we && ad == 2'd1 && !m_lock && m_guard == 0;
    fu = 0; fe = 0; acc = 0;
    if (rs_en) begin
      if (m_cnt <= m_wdd) begin acc = 1; m_cnt = m_wdv; end
      else fe = 1;
    end else if (tk && run) begin
      if (m_cnt == 0) begin fu = 1; m_cnt = m_wdv; end
      else m_cnt = m_cnt - 1;
    end
    if (acc) m_guard = 3;
    else if (tk && m_guard > 0) m_guard--;
    if (key_ok && d[1]) m_lock = 1;
    if (mw) begin
      m_ih = d[29]; m_dh = d[28]; m_wdd = d[27:16]; m_dis = d[15];
      m_ren = d[13]; m_ien = d[12]; m_wdv = d[11:0];
    end
    m_unf = fu || (m_unf && !rd);
    m_err = fe || (m_err && !rd);
  endtask

  task automatic compare();
    chk("R2 count", count_o, m_cnt);
    chk("R3 underflow flag", unf_flag_o, m_unf);
    chk("R6 error flag", err_flag_o, m_err);
    chk("R7 reset out", wdt_rst_o, m_ren && (m_unf || m_err));
    chk("R7 irq out", irq_o, m_ien && (m_unf || m_err));
  endtask

  task automatic cyc(input logic tk, we, input logic [1:0] ad, input logic [31:0] d,
                     input logic rd, idl, dbg);
    tick_i = tk; wr_en_i = we; wr_addr_i = ad; wr_data_i = d;
    stat_rd_i = rd; idle_i = idl; debug_i = dbg;
    @(posedge clk_i);
    model_step(tk, we, ad, d, rd, idl, dbg);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0; stat_rd_i = 0;
    compare();
  endtask

  task automatic idle_c();            cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic tick_c();            cyc(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic wmode(input logic [31:0] d); cyc(0, 1, 2'd1, d, 0, 0, 0); endtask
  task automatic restart();           cyc(0, 1, 2'd0, mk_ctrl(8'hA5, 0, 1), 0, 0, 0); endtask
  task automatic clr();               cyc(0, 0, 0, 0, 1, 0, 0); endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    model_reset();
    rst_ni = 1;
    @(negedge clk_i);
    compare();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp=<150000", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240517));
    model_reset();
    @(negedge clk_i);
    do_reset();
    // R1
    chk("R1 reset count", count_o, 12'hFFF);
    chk("R1 reset flags", {unf_flag_o, err_flag_o}, 0);
    chk("R1 reset outs", {wdt_rst_o, irq_o}, 0);

    repeat (5) tick_c();
    chk("R2 five ticks", count_o, 12'hFFA);
    repeat (3) idle_c();
    chk("R2 hold", count_o, 12'hFFA);

    wmode(mk_mode(1, 1, 12'd3, 0, 1, 1, 12'd5));
    restart();
    chk("R6 early restart err", err_flag_o, 1);
    chk("R6 no reload", count_o, 12'hFFA);
    chk("R7 rst routed", wdt_rst_o, 1);
    chk("R7 irq routed", irq_o, 1);
    clr();
    chk("R12 cleared", err_flag_o, 0);

    cyc(0, 1, 2'd0, mk_ctrl(8'h5A, 0, 1), 0, 0, 0);
    chk("R4 bad key no err", err_flag_o, 0);
    chk("R4 bad key count", count_o, 12'hFFA);

    repeat (4091) tick_c();
    chk("R3 reload", count_o, 12'd5);
    chk("R3 flag", unf_flag_o, 1);
    clr();

    repeat (2) tick_c();
    restart();
    chk("R5 boundary restart", count_o, 12'd5);
    chk("R5 no err", err_flag_o, 0);

    wmode(mk_mode(1, 1, 12'd3, 0, 1, 1, 12'd9));
    repeat (3) tick_c();
    restart();
    chk("R11 guarded write dropped", count_o, 12'd5);
    repeat (3) tick_c();
    wmode(mk_mode(1, 1, 12'd3, 0, 1, 1, 12'd9));
    tick_c();
    restart();
    chk("R11 write after guard", count_o, 12'd9);

    cyc(0, 1, 2'd0, mk_ctrl(8'hA5, 0, 1), 1, 0, 0);
    chk("R12 set wins over clear", err_flag_o, 1);
    clr();

    cyc(1, 0, 0, 0, 0, 1, 0);
    chk("R9 idle halt", count_o, 12'd9);
    cyc(1, 0, 0, 0, 0, 0, 1);
    chk("R9 debug halt", count_o, 12'd9);
    cyc(1, 0, 0, 0, 0, 1, 1);
    wmode(mk_mode(0, 0, 12'd3, 0, 1, 1, 12'd9));
    cyc(1, 0, 0, 0, 0, 1, 0);
    chk("R9 idle no halt", count_o, 12'd8);
    cyc(1, 0, 0, 0, 0, 0, 1);
    chk("R9 debug no halt", count_o, 12'd7);

    wmode(mk_mode(0, 0, 12'd3, 1, 1, 1, 12'd9));
    repeat (3) tick_c();
    restart();
    chk("R8 frozen", count_o, 12'd7);
    chk("R8 no fault", err_flag_o, 0);

    wmode(mk_mode(0, 0, 12'd3, 0, 0, 0, 12'd9));
    restart();
    chk("R7 flag set", err_flag_o, 1);
    chk("R7 outputs masked", {wdt_rst_o, irq_o}, 0);
    clr();

    for (int i = 0; i < 20000; i++) begin
      logic tk, we, rd, id, db;
      logic [1:0] ad;
      tk = ($urandom % 3) == 0;
      we = ($urandom % 4) == 0;
      ad = 2'($urandom % 3);
      rd = ($urandom % 8) == 0;
      id = ($urandom % 4) == 0;
      db = ($urandom % 4) == 0;
      if (ad == 2'd1)
        r = mk_mode(1'($urandom), 1'($urandom), 12'($urandom % 16), ($urandom % 8) == 0,
                    1'($urandom), 1'($urandom), 12'($urandom % 16));
      else
        r = mk_ctrl((($urandom % 8) == 0) ? 8'($urandom) : 8'hA5, 1'b0, 1'($urandom));
      cyc(tk, we, ad, r, rd, id, db);
    end

    do_reset();
    restart();
    chk("R5 default window", count_o, 12'hFFF);
    cyc(0, 1, 2'd0, mk_ctrl(8'hA5, 1, 0), 0, 0, 0);
    repeat (3) tick_c();
    wmode(mk_mode(0, 0, 12'hFFF, 0, 1, 1, 12'd2));
    restart();
    chk("R10 locked write dropped", count_o, 12'hFFF);
    do_reset();
    chk("R1 after reset", count_o, 12'hFFF);
    wmode(mk_mode(0, 0, 12'hFFF, 0, 1, 1, 12'd2));
    restart();
    chk("R10 unlocked by reset", count_o, 12'd2);

    summary();
    $finish;
  end
endmodule